// File: doc/BRIEF.md
# Compact 16-bit Instruction Processor Core

This block is a small multi-cycle processor. It reads 16-bit instruction words from one memory that holds both code and data, and executes them against sixteen 8-bit general registers and two status flags: zero (Z) and carry (C). The instruction pointer (IP) is 16 bits wide and counts in words, so each address holds one 16-bit word. A data access moves the low byte of the addressed word. Programs start at word address 0x0100.

Each instruction uses a 4-bit opcode in bits [15:12], followed by one of three operand layouts: immediate, register-direct or register-indirect. Loads and stores take their address from two registers, with R14 as the high byte and R15 as the low byte. A relative jump to itself is the stop idiom. When the core meets one, it raises `halted` and freezes.

For observation, the core shows its IP, its two flags, and any one register selected by `obs_sel`. A testbench or debug harness can follow a program clock by clock through these outputs.

Top module: `mc16_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the core clears all sixteen registers, Z, C and `halted`, and loads the IP with 0x0100.
- R2: Opcode map by bits [15:12]:
  - 0 NOP, 1 ST, 2 LD, 3 BREQ, 4 RJMP, 5 ADI, 6 LDI, 7 LSR
  - 8 LSL, 9 COM, A NEG, B MOV, C ADD, D ADC, E AND, F OR

  In a fetch cycle, `mem_addr` equals the IP. Every instruction except NOP takes one fetch cycle and one execute cycle. The IP grows by one per instruction that does not branch.
- R3: NOP is retired in its single fetch cycle and changes nothing apart from the IP.
- R4: Immediate form has the destination in [11:8] and the constant in [7:0]. LDI loads the constant. ADI adds it modulo 256. COM inverts the destination (in [11:8]) and NEG negates it. MOV (destination [11:8], source [3:0]) copies the source. None of these five changes Z or C.
- R5: ADD and ADC (destination [11:8], source [3:0]) write destination + source, plus C for ADC, modulo 256. They set C to the carry out and Z to (result == 0).
- R6: AND and OR (destination [11:8], source [3:0]) write the bitwise result and set Z to (result == 0). They leave C unchanged.
- R7: Both shifts act on the register in [11:8] and leave Z unchanged.
  - LSR moves bits right, inserts 0 at bit 7, and puts the old bit 0 into C.
  - LSL moves bits left, inserts the old C at bit 0, and puts the old bit 7 into C.
- R8: ST (data register in [3:0]) drives that register on `mem_wdata`, with `mem_addr` = {R14,R15} and `mem_we` high for exactly one cycle.
- R9: LD (data register in [3:0]) writes bits [7:0] of the word read at {R14,R15} into that register.
- R10: BREQ with Z = 1 sets the IP to (its own address + 1 + the sign-extended [7:0]). With Z = 0 it falls through.
- R11: RJMP always sets the IP to (its own address + 1 + the sign-extended [7:0]).
- R12: An RJMP with [7:0] = 0xFF raises `halted` in the cycle it executes. From then on the IP stays at that RJMP's address and no memory write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address: the IP in fetch, {R14,R15} for LD/ST |
| mem_rdata | input | 16 | Word read combinationally at `mem_addr` |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Store strobe for the current cycle |
| obs_sel | input | 4 | Register index to observe |
| obs_data | output | 8 | Content of the selected register |
| ip | output | 16 | Instruction pointer |
| halted | output | 1 | Self-jump reached; core frozen |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
ADC and LSL both read the carry flag and replace it in the same execute cycle. A fault in ordering would let the new carry leak into the result. The test vectors preset C through an LSR and then run ADC and LSL on operands whose top bit or sum produces a carry. The bench judges the case correct only when the result's low bit holds the old carry and the flag holds the new one. A second pairing is halt detection, which falls in the same cycle as the jump's IP update. That is judged by the IP landing exactly on the jump's own address when `halted` rises.

// File: rtl/mc16_pkg.sv
// Shared definitions for the compact 16-bit processor core.
// Assumes a fixed 4-bit opcode in bits [15:12] of every instruction word.
package mc16_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'h0,
        OP_ST   = 4'h1,
        OP_LD   = 4'h2,
        OP_BREQ = 4'h3,
        OP_RJMP = 4'h4,
        OP_ADI  = 4'h5,
        OP_LDI  = 4'h6,
        OP_LSR  = 4'h7,
        OP_LSL  = 4'h8,
        OP_COM  = 4'h9,
        OP_NEG  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ADD  = 4'hC,
        OP_ADC  = 4'hD,
        OP_AND  = 4'hE,
        OP_OR   = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_HALT  = 2'd2
    } phase_e;

endpackage

// File: rtl/mc16_alu.sv
// Combinational arithmetic/logic unit.
// What it does: produces the result byte, the candidate Z and C values,
// and strobes that say which of result, Z and C the opcode may change.
// Assumes: a is the destination operand, b is the source or the immediate.
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                c_in,
    output logic [DATA_W-1:0]   y,
    output logic                z_out,
    output logic                c_out,
    output logic                upd_z,
    output logic                upd_c,
    output logic                wr
);

    localparam int SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum;

    // Adder shared by ADD and ADC; only ADC feeds the carry in.
    always_comb begin
        sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, (op == OP_ADC) & c_in};
    end

    // Opcode decode: result and flag-update selection.
    always_comb begin
        y     = '0;
        c_out = c_in;
        upd_z = 1'b0;
        upd_c = 1'b0;
        wr    = 1'b1;
        case (op)
            OP_ADI:  y = a + b;
            OP_LDI:  y = b;
            OP_MOV:  y = b;
            OP_COM:  y = ~a;
            OP_NEG:  y = '0 - a;
            OP_LSR: begin
                y     = {1'b0, a[DATA_W-1:1]};
                c_out = a[0];
                upd_c = 1'b1;
            end
            OP_LSL: begin
                y     = {a[DATA_W-2:0], c_in};
                c_out = a[DATA_W-1];
                upd_c = 1'b1;
            end
            OP_ADD, OP_ADC: begin
                y     = sum[DATA_W-1:0];
                c_out = sum[DATA_W];
                upd_z = 1'b1;
                upd_c = 1'b1;
            end
            OP_AND: begin
                y     = a & b;
                upd_z = 1'b1;
            end
            OP_OR: begin
                y     = a | b;
                upd_z = 1'b1;
            end
            default: wr = 1'b0;
        endcase
    end

    // Zero detect on whatever result was formed.
    always_comb begin
        z_out = (y == '0);
    end

endmodule

// File: rtl/mc16_regfile.sv
// Architectural state: general registers plus the Z and C flags.
// What it does: one write port, two operand read ports, one observation
// port, and direct outputs of the two top registers that form the
// data address. Assumes a synchronous active-low reset clears all state.
module mc16_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    input  logic [$clog2(NREG)-1:0] obs_sel,
    input  logic                    upd_z,
    input  logic                    z_in,
    input  logic                    upd_c,
    input  logic                    c_in,
    output logic [DATA_W-1:0]       rdata_a,
    output logic [DATA_W-1:0]       rdata_b,
    output logic [DATA_W-1:0]       obs_data,
    output logic [DATA_W-1:0]       pair_hi,
    output logic [DATA_W-1:0]       pair_lo,
    output logic                    z,
    output logic                    c
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One storage byte, written when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                         regs[g] <= '0;
            else if (we && (waddr == g))        regs[g] <= wdata;
        end
    end

    // Status flags, each changed only when its update strobe is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z <= 1'b0;
            c <= 1'b0;
        end else begin
            if (upd_z) z <= z_in;
            if (upd_c) c <= c_in;
        end
    end

    // Read ports.
    always_comb begin
        rdata_a  = regs[raddr_a];
        rdata_b  = regs[raddr_b];
        obs_data = regs[obs_sel];
        pair_hi  = regs[NREG-2];
        pair_lo  = regs[NREG-1];
    end

    // R4: a written value is present in the addressed register next cycle.
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(waddr)] == $past(wdata)));

    // R6: carry holds whenever no update is requested.
    assert_carry_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_c |=> (c == $past(c)));

    // R7: zero flag holds whenever no update is requested.
    assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_z |=> (z == $past(z)));

endmodule

// File: rtl/mc16_seq.sv
// Fetch/execute sequencer and instruction pointer.
// What it does: latches the fetched word, advances the IP, retires NOP
// inside the fetch cycle, applies relative branches, and detects a
// self-jump as the stop condition. Assumes the memory read is combinational.
module mc16_seq
    import mc16_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_IP = 16'h0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_in,
    input  logic                z,
    output logic [ADDR_W-1:0]   ip,
    output logic [INSTR_W-1:0]  ir,
    output phase_e              phase,
    output logic                halted
);

    opcode_e            ir_op;
    opcode_e            fetch_op;
    logic [ADDR_W-1:0]  offset;
    logic               take;
    logic               self_loop;

    // Decode of the held and the incoming instruction word.
    always_comb begin
        ir_op     = opcode_e'(ir[15:12]);
        fetch_op  = opcode_e'(instr_in[15:12]);
        offset    = {{(ADDR_W-8){ir[7]}}, ir[7:0]};
        take      = (ir_op == OP_RJMP) || ((ir_op == OP_BREQ) && z);
        self_loop = (ir_op == OP_RJMP) && (ir[7:0] == 8'hFF);
    end

    // Phase machine, IP and instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip    <= RESET_IP;
            ir    <= '0;
            phase <= PH_FETCH;
        end else begin
            case (phase)
                PH_FETCH: begin
                    ir    <= instr_in;
                    ip    <= ip + 1'b1;
                    phase <= (fetch_op == OP_NOP) ? PH_FETCH : PH_EXEC;
                end
                PH_EXEC: begin
                    if (take) ip <= ip + offset;
                    phase <= self_loop ? PH_HALT : PH_FETCH;
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    // Halt indication.
    always_comb begin
        halted = (phase == PH_HALT);
    end

    // R1: reset release shows the start address and no halt.
    assert_reset_ip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ip == RESET_IP) && !halted);

    // R3: a NOP word seen in fetch is retired in that one cycle.
    assert_nop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && fetch_op == OP_NOP)
        |=> (phase == PH_FETCH) && (ip == ADDR_W'($past(ip) + 1'b1)));

    // R11: an unconditional jump lands at the offset from the next word.
    assert_jump_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && ir_op == OP_RJMP)
        |=> (ip == ADDR_W'($past(ip) + {{(ADDR_W-8){$past(ir[7])}}, $past(ir[7:0])})));

    // R12: once halted, the core stays halted with a frozen IP.
    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(ip));

endmodule

// File: rtl/mc16_core.sv
// Top of the compact 16-bit processor core.
// What it does: ties the sequencer, register file and ALU together and
// muxes the single memory port between instruction fetch and LD/ST.
// Assumes a word-addressed memory with combinational read and a write
// that takes effect at the clock edge where mem_we is high.
module mc16_core
    import mc16_pkg::*;
#(
    parameter int                     DATA_W   = 8,
    parameter logic [2*DATA_W-1:0]    RESET_IP = 16'h0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [2*DATA_W-1:0]  mem_addr,
    input  logic [INSTR_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_we,
    input  logic [3:0]           obs_sel,
    output logic [DATA_W-1:0]    obs_data,
    output logic [2*DATA_W-1:0]  ip,
    output logic                 halted,
    output logic                 flag_z,
    output logic                 flag_c
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam int NREG   = 16;
    localparam int IDX_W  = $clog2(NREG);

    logic [INSTR_W-1:0] ir;
    phase_e             phase;
    opcode_e            op;
    logic               exec;
    logic               is_mem;
    logic [DATA_W-1:0]  rdata_a, rdata_b, pair_hi, pair_lo;
    logic [DATA_W-1:0]  alu_b, alu_y;
    logic               alu_z, alu_c, alu_upd_z, alu_upd_c, alu_wr;
    logic               rf_we;
    logic [IDX_W-1:0]   rf_waddr;
    logic [DATA_W-1:0]  rf_wdata;

    mc16_seq #(
        .ADDR_W   (ADDR_W),
        .RESET_IP (RESET_IP)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr_in (mem_rdata),
        .z        (flag_z),
        .ip       (ip),
        .ir       (ir),
        .phase    (phase),
        .halted   (halted)
    );

    // Execute-cycle decode and operand steering.
    always_comb begin
        op       = opcode_e'(ir[15:12]);
        exec     = (phase == PH_EXEC);
        is_mem   = (op == OP_LD) || (op == OP_ST);
        alu_b    = ((op == OP_ADI) || (op == OP_LDI)) ? ir[7:0] : rdata_b;
        rf_we    = exec && (alu_wr || (op == OP_LD));
        rf_waddr = (op == OP_LD) ? ir[3:0] : ir[11:8];
        rf_wdata = (op == OP_LD) ? mem_rdata[DATA_W-1:0] : alu_y;
    end

    // Memory port: fetch at the IP, data access at the register pair.
    always_comb begin
        mem_addr  = (exec && is_mem) ? {pair_hi, pair_lo} : ip;
        mem_we    = exec && (op == OP_ST);
        mem_wdata = rdata_b;
    end

    mc16_alu #(
        .DATA_W (DATA_W)
    ) i_alu (
        .op    (op),
        .a     (rdata_a),
        .b     (alu_b),
        .c_in  (flag_c),
        .y     (alu_y),
        .z_out (alu_z),
        .c_out (alu_c),
        .upd_z (alu_upd_z),
        .upd_c (alu_upd_c),
        .wr    (alu_wr)
    );

    mc16_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) i_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .raddr_a  (ir[11:8]),
        .raddr_b  (ir[3:0]),
        .obs_sel  (obs_sel),
        .upd_z    (exec && alu_upd_z),
        .z_in     (alu_z),
        .upd_c    (exec && alu_upd_c),
        .c_in     (alu_c),
        .rdata_a  (rdata_a),
        .rdata_b  (rdata_b),
        .obs_data (obs_data),
        .pair_hi  (pair_hi),
        .pair_lo  (pair_lo),
        .z        (flag_z),
        .c        (flag_c)
    );

    // R8: a store strobe never lasts into a second cycle.
    assert_store_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R12: no store is issued while halted.
    assert_halt_no_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

endmodule

// File: tb/test_mc16_core.sv
`timescale 1ns/1ps
module test_mc16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [3:0]  obs_sel = 4'd0;
    logic [7:0]  obs_data;
    logic [15:0] ip;
    logic        halted;
    logic        flag_z, flag_c;

    int checks = 0;
    int fails  = 0;
    int we_count = 0;

    logic [15:0] mem [1024];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[mem_addr[9:0]] <= {8'h00, mem_wdata};
            we_count <= we_count + 1;
        end
    end

    mc16_core i_mc16_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .obs_sel(obs_sel),
        .obs_data(obs_data), .ip(ip), .halted(halted),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    // Fields: [30:27] op, [26:19] dst, [18:11] src/imm, [10] C in,
    // [9:2] expected result, [1] expected Z, [0] expected C.
    localparam logic [30:0] VECS [13] = '{
        {4'hC, 8'h80, 8'h80, 1'b0, 8'h00, 1'b1, 1'b1},
        {4'hC, 8'h12, 8'h34, 1'b1, 8'h46, 1'b0, 1'b0},
        {4'hD, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1},
        {4'hD, 8'h10, 8'h20, 1'b1, 8'h31, 1'b0, 1'b0},
        {4'hE, 8'hF0, 8'h0F, 1'b1, 8'h00, 1'b1, 1'b1},
        {4'hF, 8'hA0, 8'h05, 1'b0, 8'hA5, 1'b0, 1'b0},
        {4'h7, 8'h81, 8'h00, 1'b0, 8'h40, 1'b0, 1'b1},
        {4'h8, 8'h81, 8'h00, 1'b1, 8'h03, 1'b0, 1'b1},
        {4'h8, 8'h40, 8'h00, 1'b1, 8'h81, 1'b0, 1'b0},
        {4'h9, 8'h5A, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b1},
        {4'hA, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0},
        {4'hB, 8'h13, 8'h77, 1'b1, 8'h77, 1'b0, 1'b1},
        {4'h5, 8'hF0, 8'h20, 1'b1, 8'h10, 1'b0, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    endtask

    task automatic read_reg(input int idx, output logic [7:0] v);
        obs_sel = 4'(idx);
        #1;
        v = obs_data;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_to_halt(input string tag);
        hold_reset();
        rst_n = 1'b1;
        for (int n = 0; n < 300 && !halted; n++) @(negedge clk);
        check(halted, tag, "halt reached", int'(halted), 1);
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'hC, 4'hD: return "R5";
            4'hE, 4'hF: return "R6";
            4'h7, 4'h8: return "R7";
            default:    return "R4";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] ip_hold;
        int          we_hold;

        // Table walk: preset C via LSR, load operands, run one op, stop.
        for (int k = 0; k < 13; k++) begin
            logic [3:0] op;
            logic [7:0] a, b, res;
            logic       cin, ez, ec;
            {op, a, b, cin, res, ez, ec} = VECS[k];
            clear_mem();
            mem[10'h100] = {8'h61, 7'b0, cin};
            mem[10'h101] = 16'h7100;
            mem[10'h102] = {8'h62, a};
            mem[10'h103] = {8'h63, b};
            if (op == 4'h5)                   mem[10'h104] = {8'h52, b};
            else if (op inside {4'h7, 4'h8, 4'h9, 4'hA}) mem[10'h104] = {op, 4'h2, 8'h00};
            else                              mem[10'h104] = {op, 4'h2, 8'h03};
            mem[10'h105] = 16'h40FF;
            run_to_halt(tag_of(op));
            read_reg(2, v);
            check(v == res, tag_of(op), $sformatf("vector %0d result", k), v, res);
            check(flag_z == ez, tag_of(op), $sformatf("vector %0d Z", k), flag_z, ez);
            check(flag_c == ec, tag_of(op), $sformatf("vector %0d C", k), flag_c, ec);
        end

        // R1: reset after a dirty run clears everything.
        hold_reset();
        check(ip == 16'h0100, "R1", "reset IP", ip, 16'h0100);
        check(!halted, "R1", "reset halted", halted, 0);
        check(!flag_z && !flag_c, "R1", "reset flags", {flag_z, flag_c}, 0);
        for (int r = 0; r < 16; r++) begin
            read_reg(r, v);
            check(v == 8'h00, "R1", $sformatf("reset R%0d", r), v, 0);
        end

        // R2: two-cycle instructions and fetch address.
        clear_mem();
        mem[10'h100] = 16'h6101;
        mem[10'h101] = 16'h6202;
        mem[10'h102] = 16'h40FF;
        hold_reset();
        rst_n = 1'b1;
        #1;
        check(mem_addr == 16'h0100, "R2", "first fetch address", mem_addr, 16'h0100);
        repeat (2) @(negedge clk);
        read_reg(1, v);
        check(ip == 16'h0101, "R2", "IP after one instruction", ip, 16'h0101);
        check(v == 8'h01, "R2", "R1 after LDI", v, 1);
        repeat (4) @(negedge clk);
        check(halted && ip == 16'h0102, "R2", "halt after 6 cycles", ip, 16'h0102);

        // R3: NOPs retire in one cycle each; then halt on the self-jump.
        clear_mem();
        mem[10'h103] = 16'h40FF;
        hold_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ip == 16'h0103, "R3", "IP after three NOPs", ip, 16'h0103);
        check(!flag_z && !flag_c, "R3", "flags after NOPs", {flag_z, flag_c}, 0);
        repeat (2) @(negedge clk);
        check(halted, "R12", "halted after self-jump", halted, 1);
        check(ip == 16'h0103, "R12", "IP parked on self-jump", ip, 16'h0103);

        // R8 / R9: store then load via {R14,R15}; load of a preset word.
        clear_mem();
        mem[10'h211] = 16'hAB5E;
        mem[10'h100] = 16'h6E02;
        mem[10'h101] = 16'h6F10;
        mem[10'h102] = 16'h66C3;
        mem[10'h103] = 16'h1006;
        mem[10'h104] = 16'h2007;
        mem[10'h105] = 16'h6F11;
        mem[10'h106] = 16'h2008;
        mem[10'h107] = 16'h40FF;
        we_count = 0;
        run_to_halt("R8");
        check(mem[10'h210] == 16'h00C3, "R8", "stored byte", mem[10'h210], 16'h00C3);
        check(we_count == 1, "R8", "store strobe cycles", we_count, 1);
        read_reg(7, v);
        check(v == 8'hC3, "R9", "load back", v, 8'hC3);
        read_reg(8, v);
        check(v == 8'h5E, "R9", "load low byte", v, 8'h5E);

        // R10: BREQ taken when Z = 1.
        clear_mem();
        mem[10'h100] = 16'h6100;
        mem[10'h101] = 16'hC101;
        mem[10'h102] = 16'h3001;
        mem[10'h103] = 16'h6211;
        mem[10'h104] = 16'h6322;
        mem[10'h105] = 16'h40FF;
        run_to_halt("R10");
        read_reg(2, v);
        check(v == 8'h00, "R10", "taken branch skipped LDI", v, 0);
        read_reg(3, v);
        check(v == 8'h22, "R10", "taken branch target ran", v, 8'h22);

        // R10: BREQ falls through when Z = 0.
        mem[10'h100] = 16'h6101;
        run_to_halt("R10");
        read_reg(2, v);
        check(v == 8'h11, "R10", "untaken branch fell through", v, 8'h11);

        // R11: forward RJMP skips one word.
        clear_mem();
        mem[10'h100] = 16'h4001;
        mem[10'h101] = 16'h6255;
        mem[10'h102] = 16'h6366;
        mem[10'h103] = 16'h40FF;
        run_to_halt("R11");
        read_reg(2, v);
        check(v == 8'h00, "R11", "jumped-over LDI", v, 0);
        read_reg(3, v);
        check(v == 8'h66, "R11", "jump target ran", v, 8'h66);

        // R12: halted state is frozen.
        ip_hold = ip;
        we_hold = we_count;
        repeat (10) @(negedge clk);
        check(ip == ip_hold && ip == 16'h0103, "R12", "IP frozen", ip, 16'h0103);
        check(we_count == we_hold, "R12", "no store while halted", we_count, we_hold);
        check(halted, "R12", "still halted", halted, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule